// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block is the control state machine of a jitter-attenuating clock synchronizer. It moves the synchronizer through five operating modes: initialization, free-run, lock acquisition, locked and holdover. It decides which reference input the loop follows and whether the loop runs with the fast or the normal bandwidth. It also gates the output clocks and tells the serial interface when it may accept traffic. The analog loop, the input qualification circuits and the configuration store are outside the block. Each of them is seen only as a flag or a simple request/done handshake.

A hard reset comes from the active-low reset pin or from a register bit. It puts every output back to its power-up state and starts a fresh configuration load. A soft reset leaves the configuration and the serial interface alone and only restarts the mode sequence from free-run. In the locked and acquiring modes, a failure of the selected input has three possible outcomes. The block moves to another valid input, or falls back to holdover when the history is usable, or returns to free-run.

Top module: `clksync_mode_ctrl`

## Requirements
- R1: At any clock edge where `rst_n_pin` is 0 or `hard_rst_bit` is 1, the outputs take these values in the next cycle, whatever the other inputs are (a soft reset included): `mode`=0, `cfg_load_req`=1, `ser_ready`=0, `out_en`=0, `lol`=1, `bw_fast`=0, `sel_idx`=0.
- R2: `out_en` and `ser_ready` are 1 in every cycle where `mode` is not 0 (init), and 0 in every cycle where it is 0.
- R3: The mode codes are 0 init, 1 free-run, 2 acquire, 3 locked and 4 holdover. In init, the block moves to free-run on the edge after `cfg_load_done` is seen at 1, and `cfg_load_req` falls in the same cycle. Until then it stays in init with `cfg_load_req` at 1.
- R4: A soft reset (`soft_rst_bit`=1) outside init sends the block to free-run with `sel_idx`=0 on the next edge. `cfg_load_req` stays 0 and `ser_ready` stays 1. In init, a soft reset has no effect.
- R5: In free-run or holdover, if any bit of `clk_valid` is 1, the block enters acquire on the next edge, with `sel_idx` set to the lowest-numbered valid input.
- R6: `bw_fast` is 1 in a cycle exactly when that cycle's mode is acquire and `fastlock_en` was 1 at the edge that produced it.
- R7: In acquire, with the selected input valid and `lock_ok` at 1, the block enters locked on the next edge. `lol` is 0 only in cycles where `mode` is 3.
- R8: In locked, if the selected input goes invalid while another input is valid, the block returns to acquire on the lowest-numbered valid input.
- R9: In locked, if the selected input goes invalid and no input is valid, the block enters holdover when `hist_valid` is 1 and free-run when it is 0.
- R10: In holdover, with no input valid, the block stays in holdover.
- R11: In acquire, a failure of the selected input takes precedence over `lock_ok`. The block goes to the lowest valid input and stays in acquire, or goes to free-run when no input is valid. In locked, if `lock_ok` falls while the selected input is still valid, the block returns to acquire on the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_pin | input | 1 | Active-low hard reset pin, sampled synchronously |
| hard_rst_bit | input | 1 | Hard reset request from the register bank |
| soft_rst_bit | input | 1 | Soft reset request from the register bank |
| cfg_load_done | input | 1 | Configuration store finished loading |
| clk_valid | input | N_IN | Per-input qualification flags |
| lock_ok | input | 1 | Phase lock achieved on the selected input |
| hist_valid | input | 1 | Holdover history is usable |
| fastlock_en | input | 1 | Use the fast bandwidth while acquiring |
| mode | output | 3 | Current mode code |
| sel_idx | output | SEL_W | Index of the selected input |
| bw_fast | output | 1 | 1 selects the fast loop bandwidth |
| out_en | output | 1 | Output clock enable |
| ser_ready | output | 1 | Serial interface may be used |
| lol | output | 1 | Loss-of-lock flag |
| cfg_load_req | output | 1 | Request to load configuration from the store |

## Verification
Two cases can fall in the same cycle. In acquire, lock can be achieved in the same cycle that the selected input fails. A hard and a soft reset can also be requested together. The bench forces both cases directly: it raises `lock_ok` in the cycle where the selected bit of `clk_valid` drops, and it sets both reset bits at once. It then expects the failure branch (R11) to win over the lock, and the hard reset (R1) to win over the soft one. Constrained random runs produce more such collisions, and a cycle-level reference model built from the requirements judges each of them.

// File: rtl/clksync_pkg.sv
package clksync_pkg;
  typedef enum logic [2:0] {
    M_INIT = 3'd0,
    M_FREE = 3'd1,
    M_ACQ  = 3'd2,
    M_LOCK = 3'd3,
    M_HOLD = 3'd4
  } mode_e;
endpackage

// File: rtl/clksync_lowest_sel.sv
module clksync_lowest_sel #(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_IN-1:0]  vld,
  output logic             any,
  output logic [SEL_W-1:0] idx
);
  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (vld[i]) idx = SEL_W'(i);
    end
  end

  assign any = |vld;
endmodule

// File: rtl/clksync_mode_next.sv
module clksync_mode_next
  import clksync_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input  mode_e            cur_mode,
  input  logic [SEL_W-1:0] cur_sel,
  input  logic [N_IN-1:0]  clk_valid,
  input  logic             any_valid,
  input  logic [SEL_W-1:0] low_idx,
  input  logic             soft_req,
  input  logic             cfg_done,
  input  logic             lock_ok,
  input  logic             hist_valid,
  output mode_e            nxt_mode,
  output logic [SEL_W-1:0] nxt_sel
);
  logic sel_ok;
  assign sel_ok = clk_valid[cur_sel];

  always_comb begin
    nxt_mode = cur_mode;
    nxt_sel  = cur_sel;
    if (soft_req && cur_mode != M_INIT) begin
      nxt_mode = M_FREE;
      nxt_sel  = '0;
    end else begin
      unique case (cur_mode)
        M_INIT: begin
          if (cfg_done) nxt_mode = M_FREE;
        end
        M_FREE, M_HOLD: begin
          if (any_valid) begin
            nxt_mode = M_ACQ;
            nxt_sel  = low_idx;
          end
        end
        M_ACQ: begin
          if (!sel_ok) begin
            if (any_valid) begin
              nxt_mode = M_ACQ;
              nxt_sel  = low_idx;
            end else begin
              nxt_mode = M_FREE;
            end
          end else if (lock_ok) begin
            nxt_mode = M_LOCK;
          end
        end
        M_LOCK: begin
          if (!sel_ok) begin
            if (any_valid) begin
              nxt_mode = M_ACQ;
              nxt_sel  = low_idx;
            end else if (hist_valid) begin
              nxt_mode = M_HOLD;
            end else begin
              nxt_mode = M_FREE;
            end
          end else if (!lock_ok) begin
            nxt_mode = M_ACQ;
          end
        end
        default: nxt_mode = M_FREE;
      endcase
    end
  end
endmodule

// File: rtl/clksync_out_reg.sv
module clksync_out_reg
  import clksync_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            nxt_mode,
  input  logic [SEL_W-1:0] nxt_sel,
  input  logic             fastlock_en,
  output mode_e            mode_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             bw_fast_q,
  output logic             out_en_q,
  output logic             ser_ready_q,
  output logic             lol_q,
  output logic             cfg_req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_INIT;
      sel_q       <= '0;
      bw_fast_q   <= 1'b0;
      out_en_q    <= 1'b0;
      ser_ready_q <= 1'b0;
      lol_q       <= 1'b1;
      cfg_req_q   <= 1'b1;
    end else begin
      mode_q      <= nxt_mode;
      sel_q       <= nxt_sel;
      bw_fast_q   <= (nxt_mode == M_ACQ) && fastlock_en;
      out_en_q    <= (nxt_mode != M_INIT);
      ser_ready_q <= (nxt_mode != M_INIT);
      lol_q       <= (nxt_mode != M_LOCK);
      cfg_req_q   <= (nxt_mode == M_INIT);
    end
  end
endmodule

// File: rtl/clksync_mode_ctrl.sv
module clksync_mode_ctrl
  import clksync_pkg::*;
#(
  parameter int N_IN  = 4,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n_pin,
  input  logic             hard_rst_bit,
  input  logic             soft_rst_bit,
  input  logic             cfg_load_done,
  input  logic [N_IN-1:0]  clk_valid,
  input  logic             lock_ok,
  input  logic             hist_valid,
  input  logic             fastlock_en,
  output logic [2:0]       mode,
  output logic [SEL_W-1:0] sel_idx,
  output logic             bw_fast,
  output logic             out_en,
  output logic             ser_ready,
  output logic             lol,
  output logic             cfg_load_req
);
  logic             hard_rst;
  logic             any_valid;
  logic [SEL_W-1:0] low_idx;
  mode_e            cur_mode;
  mode_e            nxt_mode;
  logic [SEL_W-1:0] nxt_sel;

  assign hard_rst = !rst_n_pin || hard_rst_bit;

  clksync_lowest_sel #(.N_IN(N_IN), .SEL_W(SEL_W)) u_sel (
    .vld (clk_valid),
    .any (any_valid),
    .idx (low_idx)
  );

  clksync_mode_next #(.N_IN(N_IN), .SEL_W(SEL_W)) u_next (
    .cur_mode   (cur_mode),
    .cur_sel    (sel_idx),
    .clk_valid  (clk_valid),
    .any_valid  (any_valid),
    .low_idx    (low_idx),
    .soft_req   (soft_rst_bit),
    .cfg_done   (cfg_load_done),
    .lock_ok    (lock_ok),
    .hist_valid (hist_valid),
    .nxt_mode   (nxt_mode),
    .nxt_sel    (nxt_sel)
  );

  clksync_out_reg #(.SEL_W(SEL_W)) u_reg (
    .clk         (clk),
    .rst         (hard_rst),
    .nxt_mode    (nxt_mode),
    .nxt_sel     (nxt_sel),
    .fastlock_en (fastlock_en),
    .mode_q      (cur_mode),
    .sel_q       (sel_idx),
    .bw_fast_q   (bw_fast),
    .out_en_q    (out_en),
    .ser_ready_q (ser_ready),
    .lol_q       (lol),
    .cfg_req_q   (cfg_load_req)
  );

  assign mode = cur_mode;
endmodule

// File: rtl/clksync_mode_ctrl_chk.sv
module clksync_mode_ctrl_chk #(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n_pin,
  input logic             hard_rst_bit,
  input logic             soft_rst_bit,
  input logic [N_IN-1:0]  clk_valid,
  input logic             hist_valid,
  input logic [2:0]       mode,
  input logic [SEL_W-1:0] sel_idx,
  input logic             bw_fast,
  input logic             out_en,
  input logic             lol,
  input logic             cfg_load_req
);
  logic            seen = 1'b0;
  logic [N_IN-1:0] vld_q;
  logic            hard;
  logic            quiet;

  assign hard  = !rst_n_pin || hard_rst_bit;
  assign quiet = !hard && !soft_rst_bit;

  always_ff @(posedge clk) begin
    seen  <= 1'b1;
    vld_q <= clk_valid;
  end

  a_r1_hard_reset: assert property (@(posedge clk) disable iff (!seen)
    hard |=> (mode == 3'd0 && cfg_load_req && !out_en && lol));

  a_r2_outen_mode: assert property (@(posedge clk) disable iff (!seen)
    out_en == (mode != 3'd0));

  a_r7_lol_mode: assert property (@(posedge clk) disable iff (!seen)
    lol == (mode != 3'd3));

  a_r6_bw_acq: assert property (@(posedge clk) disable iff (!seen)
    bw_fast |-> mode == 3'd2);

  a_r5_pick_valid: assert property (@(posedge clk) disable iff (!seen)
    (quiet && mode == 3'd1 && |clk_valid) |=> (mode == 3'd2 && vld_q[sel_idx]));

  a_r9_holdover: assert property (@(posedge clk) disable iff (!seen)
    (quiet && mode == 3'd3 && clk_valid == '0 && hist_valid) |=> mode == 3'd4);

  a_r10_hold_stay: assert property (@(posedge clk) disable iff (!seen)
    (quiet && mode == 3'd4 && clk_valid == '0) |=> mode == 3'd4);
endmodule

bind clksync_mode_ctrl clksync_mode_ctrl_chk #(.N_IN(N_IN), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n_pin    (rst_n_pin),
  .hard_rst_bit (hard_rst_bit),
  .soft_rst_bit (soft_rst_bit),
  .clk_valid    (clk_valid),
  .hist_valid   (hist_valid),
  .mode         (mode),
  .sel_idx      (sel_idx),
  .bw_fast      (bw_fast),
  .out_en       (out_en),
  .lol          (lol),
  .cfg_load_req (cfg_load_req)
);

// File: tb/clksync_mode_ctrl_test.sv
`timescale 1ns/1ps
module clksync_mode_ctrl_test;
  localparam int N_IN  = 4;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst_n_pin = 1'b0;
  logic             hard_rst_bit = 1'b0;
  logic             soft_rst_bit = 1'b0;
  logic             cfg_load_done = 1'b0;
  logic [N_IN-1:0]  clk_valid = '0;
  logic             lock_ok = 1'b0;
  logic             hist_valid = 1'b0;
  logic             fastlock_en = 1'b0;
  logic [2:0]       mode;
  logic [SEL_W-1:0] sel_idx;
  logic             bw_fast, out_en, ser_ready, lol, cfg_load_req;

  int checks = 0;
  int fails  = 0;

  // expected state
  int e_mode = 0;
  int e_sel  = 0;
  int e_bw   = 0;

  always #10 clk = ~clk;

  clksync_mode_ctrl #(.N_IN(N_IN)) uut (
    .clk(clk), .rst_n_pin(rst_n_pin), .hard_rst_bit(hard_rst_bit),
    .soft_rst_bit(soft_rst_bit), .cfg_load_done(cfg_load_done),
    .clk_valid(clk_valid), .lock_ok(lock_ok), .hist_valid(hist_valid),
    .fastlock_en(fastlock_en), .mode(mode), .sel_idx(sel_idx),
    .bw_fast(bw_fast), .out_en(out_en), .ser_ready(ser_ready), .lol(lol),
    .cfg_load_req(cfg_load_req)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(logic [N_IN-1:0] v);
    for (int i = 0; i < N_IN; i++) if (v[i]) return i;
    return 0;
  endfunction

  // Reference model of the next state, from the requirements.
  task automatic model_step();
    int m = e_mode;
    int s = e_sel;
    bit any = |clk_valid;
    bit ok  = clk_valid[e_sel];
    if (!rst_n_pin || hard_rst_bit) begin
      m = 0; s = 0;                                   // R1
    end else if (soft_rst_bit && e_mode != 0) begin
      m = 1; s = 0;                                   // R4
    end else begin
      case (e_mode)
        0: if (cfg_load_done) m = 1;                  // R3
        1, 4: if (any) begin m = 2; s = lowest(clk_valid); end  // R5 R10
        2: if (!ok) begin
             if (any) s = lowest(clk_valid); else m = 1;        // R11
           end else if (lock_ok) m = 3;               // R7
        3: if (!ok) begin
             if (any) begin m = 2; s = lowest(clk_valid); end   // R8
             else m = hist_valid ? 4 : 1;             // R9
           end else if (!lock_ok) m = 2;              // R11
        default: m = 1;
      endcase
    end
    e_bw   = (m == 2 && fastlock_en && rst_n_pin && !hard_rst_bit) ? 1 : 0;  // R6
    e_mode = m;
    e_sel  = s;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    check("R3 mode", int'(mode), e_mode);
    check("R5 sel_idx", int'(sel_idx), e_sel);
    check("R6 bw_fast", int'(bw_fast), e_bw);
    check("R2 out_en", int'(out_en), (e_mode != 0) ? 1 : 0);
    check("R2 ser_ready", int'(ser_ready), (e_mode != 0) ? 1 : 0);
    check("R7 lol", int'(lol), (e_mode != 3) ? 1 : 0);
    check("R1 cfg_load_req", int'(cfg_load_req), (e_mode == 0) ? 1 : 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5eed_1234);
    // R1 reset state
    step(); step();
    check("R1 reset mode", int'(mode), 0);
    check("R1 reset ser_ready", int'(ser_ready), 0);
    rst_n_pin = 1'b1;
    // R3 waits for load done
    step(); step();
    check("R3 still init", int'(mode), 0);
    cfg_load_done = 1'b1; step(); cfg_load_done = 1'b0;
    check("R3 to free-run", int'(mode), 1);
    check("R2 outputs on", int'(out_en), 1);
    // R5 R6 lowest valid, fast bw
    fastlock_en = 1'b1; clk_valid = 4'b0110; step();
    check("R5 acquire", int'(mode), 2);
    check("R5 lowest sel", int'(sel_idx), 1);
    check("R6 fast bw", int'(bw_fast), 1);
    lock_ok = 1'b1; step();
    check("R7 locked", int'(mode), 3);
    check("R7 lol low", int'(lol), 0);
    check("R6 normal bw", int'(bw_fast), 0);
    // R8 switch
    clk_valid = 4'b0100; lock_ok = 1'b0; step();
    check("R8 switch mode", int'(mode), 2);
    check("R8 switch sel", int'(sel_idx), 2);
    lock_ok = 1'b1; step();
    // R9 holdover
    clk_valid = 4'b0000; hist_valid = 1'b1; step();
    check("R9 holdover", int'(mode), 4);
    step();
    check("R10 stays holdover", int'(mode), 4);
    clk_valid = 4'b1000; lock_ok = 1'b0; step();
    check("R5 from holdover sel", int'(sel_idx), 3);
    lock_ok = 1'b1; step();
    clk_valid = 4'b0000; hist_valid = 1'b0; step();
    check("R9 to free-run", int'(mode), 1);
    // R11 failure beats lock in the same cycle
    lock_ok = 1'b0; clk_valid = 4'b0001; step();
    lock_ok = 1'b1; clk_valid = 4'b0010; step();
    check("R11 fail wins mode", int'(mode), 2);
    check("R11 fail wins sel", int'(sel_idx), 1);
    step();
    check("R7 locked again", int'(mode), 3);
    // R11 lock drop with input still valid
    lock_ok = 1'b0; step();
    check("R11 relock same sel", int'(sel_idx), 1);
    check("R11 relock mode", int'(mode), 2);
    // R4 soft reset
    soft_rst_bit = 1'b1; step(); soft_rst_bit = 1'b0;
    check("R4 soft to free", int'(mode), 1);
    check("R4 no load", int'(cfg_load_req), 0);
    check("R4 ready kept", int'(ser_ready), 1);
    // R1 hard and soft together
    clk_valid = 4'b0000;
    hard_rst_bit = 1'b1; soft_rst_bit = 1'b1; step();
    hard_rst_bit = 1'b0;
    check("R1 hard beats soft", int'(mode), 0);
    step();
    check("R4 soft ignored in init", int'(mode), 0);
    soft_rst_bit = 1'b0;
    cfg_load_done = 1'b1; step();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      rst_n_pin     = ($urandom % 300) != 0;
      hard_rst_bit  = ($urandom % 250) == 0;
      soft_rst_bit  = ($urandom % 120) == 0;
      cfg_load_done = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) clk_valid = N_IN'($urandom);
      if (($urandom % 5) == 0) clk_valid[$urandom % N_IN] = 1'b0;
      lock_ok       = ($urandom % 3) != 0;
      hist_valid    = ($urandom % 2) == 0;
      fastlock_en   = ($urandom % 4) != 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule